// File: doc/BRIEF.md
# Short-Circuit Off-Time and Thermal Shutdown Sequencer

This block guards a step-down switching regulator against a shorted output and against overheating. It watches four comparator flags from the analog side: one says the peak inductor current sits at its steady-state limit, one says the output has collapsed to the short-circuit threshold or below, and two say the die is hotter than an upper and a lower temperature threshold. All four flags are brought into the clock domain through a synchronizer of `SYNC_STAGES` flops.

A short is acted on only after both the current flag and the low-output flag have stayed true together for longer than a qualification window of `QUAL_CYC` cycles. The sequencer then holds the high-side switch off for a fixed `OFF_CYC` cycles and returns to normal operation on its own. If the short is still present, a fresh full qualification window must pass before the next off interval. A hot die overrides all of this. The device is shut down and the switch held off for as long as the die stays warm. Operation resumes only after both temperature flags have cleared, which gives hysteresis between entry and exit.

The four states are NORMAL, QUALIFY, TIMED_OFF and THERMAL. The transitions are:
- NORMAL→QUALIFY when both short flags are seen.
- QUALIFY→NORMAL when either short flag drops.
- QUALIFY→TIMED_OFF when the window expires.
- TIMED_OFF→NORMAL when the off interval ends.
- Any state→THERMAL when the over-temperature flag is seen.
- THERMAL→NORMAL when both temperature flags are low.

Top module: `sc_therm_guard`

## Requirements
- R1: While `rst_n` is low and directly after reset, all five outputs are 0 and the state is NORMAL.
- R2: The short-circuit condition is `ilim_at_ss` and `vout_short` both high. When it is first seen, `stat_qualify` goes high while `pfet_force_off` stays low.
- R3: TIMED_OFF is entered on the clock at which the synchronized condition has been seen on `QUAL_CYC`+1 consecutive cycles. `stat_qualify` is high for exactly `QUAL_CYC` cycles before `stat_timed_off` rises.
- R4: Either short flag alone, held for any time, never raises `stat_qualify` or `pfet_force_off`.
- R5: If either short flag drops during QUALIFY, the state returns to NORMAL and the window count is discarded. A later attempt needs the full window again.
- R6: In TIMED_OFF, `pfet_force_off` and `stat_timed_off` are high for exactly `OFF_CYC` cycles, whatever the short flags do. The state then returns to NORMAL.
- R7: If the short persists after an off interval ends, the state passes through NORMAL for one cycle and then QUALIFY. TIMED_OFF recurs only after another full window.
- R8: `temp_over_hi` seen in any state moves the state to THERMAL on the next clock. This includes QUALIFY and TIMED_OFF. In THERMAL, `dev_shutdown`, `pfet_force_off` and `stat_thermal` are high.
- R9: THERMAL has no time bound. It is left for NORMAL only on a clock where both synchronized `temp_over_hi` and `temp_over_lo` are low.
- R10: Each input flag reaches the state machine through `SYNC_STAGES` flops. An input change shows at the outputs after `SYNC_STAGES`+1 rising edges.
- R11: At most one of `stat_qualify`, `stat_timed_off` and `stat_thermal` is high. `dev_shutdown` implies `pfet_force_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ilim_at_ss | input | 1 | Peak inductor current at the steady-state limit |
| vout_short | input | 1 | Output at or below the short-circuit threshold |
| temp_over_hi | input | 1 | Die above the shutdown temperature |
| temp_over_lo | input | 1 | Die above the resume temperature |
| pfet_force_off | output | 1 | Hold the high-side switch off |
| dev_shutdown | output | 1 | Thermal shutdown of the device |
| stat_qualify | output | 1 | Short condition being qualified |
| stat_timed_off | output | 1 | Timed off interval running |
| stat_thermal | output | 1 | Thermal shutdown active |

## Verification
The short condition is applied in several forms:
- held through the whole window, which probes the exact entry cycle (one cycle early versus on time);
- broken halfway, which separates a reset counter from one that only pauses;
- one flag at a time, which catches an OR where an AND belongs;
- held across recovery, which shows that a new window is demanded.

The temperature flags are raised during NORMAL, QUALIFY and TIMED_OFF to show thermal priority. They are then cleared in two steps, upper flag first, to separate the two-threshold exit from an exit on the upper flag alone. One pass also runs the shutdown longer than the off interval to expose any hidden time limit on it.

// File: rtl/sc_therm_guard_pkg.sv
package sc_therm_guard_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_QUALIFY   = 2'd1,
        ST_TIMED_OFF = 2'd2,
        ST_THERMAL   = 2'd3
    } guard_state_e;

    localparam int FLAG_COUNT = 4;
    localparam int FLG_ILIM   = 0;
    localparam int FLG_VLOW   = 1;
    localparam int FLG_HOT    = 2;
    localparam int FLG_WARM   = 3;

endpackage

// File: rtl/sc_therm_guard_sync.sv
module sc_therm_guard_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] stg [STAGES];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) begin
                        stg[i] <= '0;
                    end
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end

            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sc_therm_guard_timer.sv
module sc_therm_guard_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          at_limit
);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign at_limit = (count == limit);

endmodule

// File: rtl/sc_therm_guard.sv
module sc_therm_guard
    import sc_therm_guard_pkg::*;
#(
    parameter int QUAL_CYC    = 1250,
    parameter int OFF_CYC     = 3750,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim_at_ss,
    input  logic vout_short,
    input  logic temp_over_hi,
    input  logic temp_over_lo,
    output logic pfet_force_off,
    output logic dev_shutdown,
    output logic stat_qualify,
    output logic stat_timed_off,
    output logic stat_thermal
);

    localparam int MAX_CYC = (QUAL_CYC > OFF_CYC) ? QUAL_CYC : OFF_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_CYC - 1);

    logic [FLAG_COUNT-1:0] flg_raw;
    logic [FLAG_COUNT-1:0] flg_s;
    logic                  short_s;
    logic                  hot_s;
    logic                  warm_s;

    guard_state_e state_q;
    guard_state_e state_d;

    logic          tmr_clr;
    logic          tmr_inc;
    logic [CW-1:0] tmr_limit;
    logic          tmr_done;

    // Bring the comparator flags into the clock domain
    assign flg_raw[FLG_ILIM] = ilim_at_ss;
    assign flg_raw[FLG_VLOW] = vout_short;
    assign flg_raw[FLG_HOT]  = temp_over_hi;
    assign flg_raw[FLG_WARM] = temp_over_lo;

    sc_therm_guard_sync #(
        .WIDTH  (FLAG_COUNT),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flg_raw),
        .q     (flg_s)
    );

    assign short_s = flg_s[FLG_ILIM] & flg_s[FLG_VLOW];
    assign hot_s   = flg_s[FLG_HOT];
    assign warm_s  = flg_s[FLG_WARM];

    // One counter shared by the qualification window and the off interval
    assign tmr_clr   = (state_d != state_q);
    assign tmr_inc   = (state_q == ST_QUALIFY) || (state_q == ST_TIMED_OFF);
    assign tmr_limit = (state_q == ST_QUALIFY) ? QUAL_LAST : OFF_LAST;

    sc_therm_guard_timer #(
        .CW (CW)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .inc      (tmr_inc),
        .limit    (tmr_limit),
        .at_limit (tmr_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions; the over-temperature flag wins in every state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (hot_s) begin
                    state_d = ST_THERMAL;
                end else if (short_s) begin
                    state_d = ST_QUALIFY;
                end
            end
            ST_QUALIFY: begin
                if (hot_s) begin
                    state_d = ST_THERMAL;
                end else if (!short_s) begin
                    state_d = ST_NORMAL;
                end else if (tmr_done) begin
                    state_d = ST_TIMED_OFF;
                end
            end
            ST_TIMED_OFF: begin
                if (hot_s) begin
                    state_d = ST_THERMAL;
                end else if (tmr_done) begin
                    state_d = ST_NORMAL;
                end
            end
            ST_THERMAL: begin
                if (!hot_s && !warm_s) begin
                    state_d = ST_NORMAL;
                end
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    // Moore outputs
    always_comb begin
        pfet_force_off = 1'b0;
        dev_shutdown   = 1'b0;
        stat_qualify   = 1'b0;
        stat_timed_off = 1'b0;
        stat_thermal   = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
            end
            ST_QUALIFY: begin
                stat_qualify = 1'b1;
            end
            ST_TIMED_OFF: begin
                pfet_force_off = 1'b1;
                stat_timed_off = 1'b1;
            end
            ST_THERMAL: begin
                pfet_force_off = 1'b1;
                dev_shutdown   = 1'b1;
                stat_thermal   = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sc_therm_guard_chk.sv
module sc_therm_guard_chk #(
    parameter int QUAL_CYC = 1250,
    parameter int OFF_CYC  = 3750
) (
    input logic clk,
    input logic rst_n,
    input logic pfet_force_off,
    input logic dev_shutdown,
    input logic stat_qualify,
    input logic stat_timed_off,
    input logic stat_thermal,
    input logic hot_s,
    input logic warm_s
);

    int unsigned qual_run;
    int unsigned off_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_run <= 0;
            off_run  <= 0;
        end else begin
            qual_run <= stat_qualify   ? qual_run + 1 : 0;
            off_run  <= stat_timed_off ? off_run + 1  : 0;
        end
    end

    assert_one_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_qualify, stat_timed_off, stat_thermal}));

    assert_shutdown_holds_switch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_shutdown |-> pfet_force_off);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !pfet_force_off && !dev_shutdown && !stat_qualify);

    assert_window_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_timed_off) |-> (qual_run == QUAL_CYC));

    assert_off_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat_timed_off) && !stat_thermal) |-> (off_run == OFF_CYC));

    assert_hot_enters_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hot_s |=> stat_thermal);

    assert_exit_both_cool_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_thermal) |-> ($past(!hot_s) && $past(!warm_s)));

endmodule

bind sc_therm_guard sc_therm_guard_chk #(
    .QUAL_CYC (QUAL_CYC),
    .OFF_CYC  (OFF_CYC)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .pfet_force_off (pfet_force_off),
    .dev_shutdown   (dev_shutdown),
    .stat_qualify   (stat_qualify),
    .stat_timed_off (stat_timed_off),
    .stat_thermal   (stat_thermal),
    .hot_s          (hot_s),
    .warm_s         (warm_s)
);

// File: tb/sc_therm_guard_tb_top.sv
`timescale 1ns/1ps
module sc_therm_guard_tb_top;

    localparam int QUAL = 1250;
    localparam int OFF  = 3750;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    // expected output vectors {pfet_force_off, dev_shutdown, stat_qualify, stat_timed_off, stat_thermal}
    localparam logic [4:0] O_NORM  = 5'b00000;
    localparam logic [4:0] O_QUAL  = 5'b00100;
    localparam logic [4:0] O_TOFF  = 5'b10010;
    localparam logic [4:0] O_THERM = 5'b11001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ilim = 1'b0, vlow = 1'b0, hot = 1'b0, warm = 1'b0;
    logic pfet_off, shut, s_q, s_t, s_th;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sc_therm_guard #(
        .QUAL_CYC    (QUAL),
        .OFF_CYC     (OFF),
        .SYNC_STAGES (SYNC)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ilim_at_ss     (ilim),
        .vout_short     (vlow),
        .temp_over_hi   (hot),
        .temp_over_lo   (warm),
        .pfet_force_off (pfet_off),
        .dev_shutdown   (shut),
        .stat_qualify   (s_q),
        .stat_timed_off (s_t),
        .stat_thermal   (s_th)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {pfet_off, shut, s_q, s_t, s_th};
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: outputs %b, expected %b", req, $time, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ilim = 1'b0; vlow = 1'b0; hot = 1'b0; warm = 1'b0;
        step(LAT + 2);
        rst_n = 1'b1;
    endtask

    // drive the short and walk to the entry of the off interval
    task automatic enter_timed_off();
        ilim = 1'b1; vlow = 1'b1;
        step(LAT + QUAL);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ilim = 1'b1; vlow = 1'b1; hot = 1'b1; warm = 1'b1;
        step(3);
        expect_out("R1 during reset", O_NORM);
        ilim = 1'b0; vlow = 1'b0; hot = 1'b0; warm = 1'b0;
        step(LAT + 1);
        rst_n = 1'b1;
        step(1);
        expect_out("R1 after reset", O_NORM);
    endtask

    task automatic t_qualify_and_retry();
        do_reset();
        ilim = 1'b1; vlow = 1'b1;
        step(LAT - 1);
        expect_out("R10 not yet through sync", O_NORM);
        step(1);
        expect_out("R2 qualify seen", O_QUAL);
        step(QUAL - 1);
        expect_out("R3 one cycle before entry", O_QUAL);
        step(1);
        expect_out("R3 timed off entered", O_TOFF);
        step(OFF - 1);
        expect_out("R6 last off cycle", O_TOFF);
        step(1);
        expect_out("R6 recovered", O_NORM);
        step(1);
        expect_out("R7 requalify", O_QUAL);
        step(QUAL - 1);
        expect_out("R7 still qualifying", O_QUAL);
        step(1);
        expect_out("R7 second off interval", O_TOFF);
    endtask

    task automatic t_single_flags();
        do_reset();
        ilim = 1'b1;
        step(QUAL + OFF / 2);
        expect_out("R4 current flag alone", O_NORM);
        ilim = 1'b0; vlow = 1'b1;
        step(QUAL + OFF / 2);
        expect_out("R4 low-output flag alone", O_NORM);
    endtask

    task automatic t_broken_window();
        do_reset();
        ilim = 1'b1; vlow = 1'b1;
        step(LAT + QUAL / 2);
        expect_out("R5 midway", O_QUAL);
        ilim = 1'b0;
        step(LAT);
        expect_out("R5 back to normal", O_NORM);
        ilim = 1'b1;
        step(LAT);
        expect_out("R5 restart", O_QUAL);
        step(QUAL - 1);
        expect_out("R5 full window again", O_QUAL);
        step(1);
        expect_out("R5 entry after full window", O_TOFF);
    endtask

    task automatic t_off_ignores_flags();
        do_reset();
        enter_timed_off();
        expect_out("R6 entered", O_TOFF);
        ilim = 1'b0; vlow = 1'b0;
        step(OFF - 1);
        expect_out("R6 held with flags gone", O_TOFF);
        step(1);
        expect_out("R6 ends on time", O_NORM);
        step(LAT + 5);
        expect_out("R6 stays normal", O_NORM);
    endtask

    task automatic t_thermal_basic();
        do_reset();
        hot = 1'b1; warm = 1'b1;
        step(LAT - 1);
        expect_out("R10 thermal latency", O_NORM);
        step(1);
        expect_out("R8 shutdown from normal", O_THERM);
        hot = 1'b0;
        step(LAT + 20);
        expect_out("R9 upper flag cleared only", O_THERM);
        warm = 1'b0;
        step(LAT);
        expect_out("R9 both cleared", O_NORM);
    endtask

    task automatic t_thermal_priority();
        do_reset();
        enter_timed_off();
        expect_out("R8 precondition off", O_TOFF);
        hot = 1'b1; warm = 1'b1;
        step(LAT);
        expect_out("R8 overrides timed off", O_THERM);
        step(OFF + 100);
        expect_out("R9 no time bound", O_THERM);
        hot = 1'b0; warm = 1'b0;
        step(LAT);
        expect_out("R9 exit to normal", O_NORM);
        step(1);
        expect_out("R7 short still present", O_QUAL);
        hot = 1'b1;
        step(LAT);
        expect_out("R8 overrides qualify", O_THERM);
    endtask

    initial begin
        t_reset();
        t_qualify_and_retry();
        t_single_flags();
        t_broken_window();
        t_off_ignores_flags();
        t_thermal_basic();
        t_thermal_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule